// File: doc/BRIEF.md
# Cross-Domain Double-Buffered Register Bank

This block is the register front end of a waveform timer whose counter runs on its own core clock. Software writes compare and delay values into bus-side shadow bytes. The whole set moves into core-side active copies only when an update is requested. Three triggers start an update: an immediate command, an end-of-cycle command, or an automatic start on a write to the high byte of the last compare register. All three share one in-flight transfer. Enabling the timer also copies the shadows. The enable bit and the commands cross the clock boundary as toggles. Two ready flags on the bus side show when the enable or a command can be changed again.

The bus port is a plain single-cycle register port. Every write completes in its cycle, and the port has no back-pressure: a write that is not allowed in the current state is dropped without notice. Software polls the status byte to learn when a write will take effect. Reads are combinational from `bus_addr`. The address map is: control 0, static configuration 1, command 2, status 3, shadow bytes from 4 upward. Shadow bytes are little-endian per compare register (compare k low byte at 4+2k, high byte at 5+2k), and the delay byte follows them. The core supplies a one-cycle end-of-cycle pulse from its counter.

Top module: `dbr_bank`

## Requirements
- R1: After reset, the status byte (address 3) reads 0x03, the control, configuration, command and shadow bytes read 0, and `core_run` and all active outputs are 0.
- R2: The run bit (control bit 0) changes only on a write made while enable-ready (status bit 0) is 1. Enable-ready is 0 from the accepted change until the core has applied it, and then `core_run` equals the new value. A run change written while enable-ready is 0 is dropped.
- R3: Control bits 7..1 are updated by a write only if the run bit read 0 before that write. They drive `core_ctl`.
- R4: The configuration byte (address 1) ignores writes while the run bit is 1. Its bit 0 selects automatic update.
- R5: A shadow byte (address 4..10 by default) accepts a write in two cases: while running with command-ready (status bit 1) at 1, or while stopped with no transfer in flight. Any other write is ignored, and each accepted value reads back.
- R6: A command write (address 2: bit 0 immediate, bit 1 end-of-cycle, immediate wins if both) is accepted only while running with command-ready at 1. The command byte reads the pending kind until the transfer completes and then clears itself. A command written while stopped leaves the command byte at 0.
- R7: An immediate command copies every shadow byte to the active outputs once, with no end-of-cycle pulse needed.
- R8: An end-of-cycle command leaves the active outputs unchanged until the first `core_eoc` pulse after the request reaches the core, and then copies all shadow bytes.
- R9: With automatic update on and the block running, an accepted write to the last compare high byte (address 9 by default) starts an end-of-cycle transfer whose content includes that byte. Writes to any other shadow byte start nothing.
- R10: While a transfer is in flight, further commands and automatic triggers have no effect, and the command byte keeps its pending kind.
- R11: A change of the run bit from 0 to 1 copies the shadows into the active outputs. The active outputs never change while the core is stopped.
- R12: The active outputs move from one complete shadow set to the next on a single core edge, and no mixed value is ever visible.
- R13: Stopping the block while an end-of-cycle transfer is pending abandons that transfer. The active outputs stay unchanged, and command-ready returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus domain clock |
| bus_rst_n | input | 1 | Bus domain asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| core_clk | input | 1 | Core domain clock |
| core_rst_n | input | 1 | Core domain asynchronous reset, active low |
| core_eoc | input | 1 | End-of-cycle pulse from the timer counter |
| core_run | output | 1 | Enable as seen by the core |
| core_ctl | output | 7 | Protected control bits, static while running |
| core_cfg | output | 8 | Static configuration byte |
| act_cmp | output | NCMP*CW | Active compare values, compare 0 in the low bits |
| act_dly | output | DW | Active delay value |

## Verification
Two functions can fall in the same bus cycle: a shadow-byte write and the start of a transfer. An automatic trigger does both in one write, so the byte being written must already be part of the set that is copied. The bench provokes this by writing a fresh value to the last compare high byte with automatic update on. It holds the end-of-cycle pulse back and confirms the active outputs are still unchanged. It then releases one pulse and requires the full new set, including that byte. A second overlap, a stop request while an end-of-cycle transfer is pending, is judged by command-ready returning while the active outputs keep their old value. Throughout the run, a core-side monitor flags any active value that is neither the old set nor the expected new set.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned A_CTL    = 0;
  localparam int unsigned A_CFG    = 1;
  localparam int unsigned A_CMD    = 2;
  localparam int unsigned A_STAT   = 3;
  localparam int unsigned A_SHD0   = 4;
  localparam int unsigned CFG_AUTO = 0;
  localparam int unsigned CMD_NOW  = 0;
  localparam int unsigned CMD_EOC  = 1;
endpackage

// File: rtl/dbr_tgl_sync.sv
module dbr_tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic tgl_out
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], tgl_in};
  end

  assign tgl_out = pipe[STAGES-1];
endmodule

// File: rtl/dbr_bus_side.sv
module dbr_bus_side
  import dbr_pkg::*;
#(
  parameter int unsigned AW      = 4,
  parameter int unsigned NSB     = 7,
  parameter int unsigned LAST_HI = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              en_ack_s,
  input  logic              s_ack_s,
  output logic              run_q,
  output logic [6:0]        ctl_hi,
  output logic [7:0]        cfg_q,
  output logic [NSB*8-1:0]  shadow,
  output logic              en_req,
  output logic              s_req,
  output logic              s_now,
  output logic              en_rdy,
  output logic              cmd_rdy,
  output logic              s_busy,
  output logic [1:0]        cmd_pend
);
  localparam logic [AW-1:0] AD_CTL  = AW'(A_CTL);
  localparam logic [AW-1:0] AD_CFG  = AW'(A_CFG);
  localparam logic [AW-1:0] AD_CMD  = AW'(A_CMD);
  localparam logic [AW-1:0] AD_STAT = AW'(A_STAT);
  localparam logic [AW-1:0] AD_SHD0 = AW'(A_SHD0);
  localparam logic [AW-1:0] AD_LAST = AW'(LAST_HI);
  localparam logic [AW:0]   AD_END  = (AW+1)'(A_SHD0 + NSB);

  logic [BYTE_W-1:0] shd [NSB];
  logic              en_busy;
  logic              in_shd, hit_shd, shd_ok;
  logic [AW-1:0]     shd_idx;
  logic              cmd_go, auto_go, issue, issue_now;

  assign en_busy = en_req ^ en_ack_s;
  assign s_busy  = s_req ^ s_ack_s;
  assign en_rdy  = ~en_busy;
  assign cmd_rdy = ~s_busy & ~en_busy;

  assign in_shd    = (addr >= AD_SHD0) && ({1'b0, addr} < AD_END);
  assign shd_idx   = addr - AD_SHD0;
  assign hit_shd   = wr_en & in_shd;
  assign shd_ok    = run_q ? cmd_rdy : ~s_busy;
  assign cmd_go    = wr_en & (addr == AD_CMD) & run_q & cmd_rdy
                   & (wdata[CMD_NOW] | wdata[CMD_EOC]);
  assign auto_go   = hit_shd & (addr == AD_LAST) & run_q & cmd_rdy & cfg_q[CFG_AUTO];
  assign issue     = cmd_go | auto_go;
  assign issue_now = cmd_go & wdata[CMD_NOW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      ctl_hi   <= '0;
      cfg_q    <= '0;
      en_req   <= 1'b0;
      s_req    <= 1'b0;
      s_now    <= 1'b0;
      cmd_pend <= '0;
    end else begin
      if (wr_en && addr == AD_CTL) begin
        if (!run_q) ctl_hi <= wdata[7:1];
        if (en_rdy && (wdata[0] != run_q)) begin
          run_q  <= wdata[0];
          en_req <= ~en_req;
        end
      end
      if (wr_en && addr == AD_CFG && !run_q) cfg_q <= wdata;
      if (issue) begin
        s_req    <= ~s_req;
        s_now    <= issue_now;
        cmd_pend <= issue_now ? 2'b01 : 2'b10;
      end else if (!s_busy) begin
        cmd_pend <= '0;
      end
    end
  end

  for (genvar j = 0; j < NSB; j++) begin : g_shd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      shd[j] <= '0;
      else if (hit_shd && shd_ok && shd_idx == AW'(j)) shd[j] <= wdata;
    end
    assign shadow[8*j +: 8] = shd[j];
  end

  always_comb begin
    rdata = '0;
    if (addr == AD_CTL)       rdata = {ctl_hi, run_q};
    else if (addr == AD_CFG)  rdata = cfg_q;
    else if (addr == AD_CMD)  rdata = {6'b0, cmd_pend};
    else if (addr == AD_STAT) rdata = {6'b0, cmd_rdy, en_rdy};
    else if (in_shd) begin
      for (int j = 0; j < NSB; j++)
        if (shd_idx == AW'(j)) rdata = shd[j];
    end
  end
endmodule

// File: rtl/dbr_core_side.sv
module dbr_core_side #(
  parameter int unsigned NSB = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req_s,
  input  logic             s_req_s,
  input  logic             run_bus,
  input  logic             s_now_bus,
  input  logic [NSB*8-1:0] shadow,
  input  logic             eoc,
  output logic             en_ack,
  output logic             s_ack,
  output logic             core_run,
  output logic [NSB*8-1:0] act_q
);
  logic en_seen, s_seen, armed;
  logic en_evt, s_evt, go_on, run_nx;
  logic s_imm, s_arm, fire_eoc, load, s_done, armed_nx;

  assign en_evt   = en_req_s ^ en_seen;
  assign s_evt    = s_req_s ^ s_seen;
  assign go_on    = en_evt & run_bus & ~core_run;
  assign run_nx   = en_evt ? run_bus : core_run;
  assign s_imm    = s_evt & s_now_bus;
  assign s_arm    = s_evt & ~s_now_bus;
  assign fire_eoc = armed & eoc & core_run;
  assign load     = go_on | (run_nx & (s_imm | fire_eoc));
  assign s_done   = s_imm | fire_eoc | ((armed | s_arm) & ~run_nx);
  assign armed_nx = run_nx & ~fire_eoc & (armed | s_arm);
  assign en_ack   = en_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_seen  <= 1'b0;
      s_seen   <= 1'b0;
      armed    <= 1'b0;
      s_ack    <= 1'b0;
      core_run <= 1'b0;
      act_q    <= '0;
    end else begin
      en_seen  <= en_req_s;
      s_seen   <= s_req_s;
      core_run <= run_nx;
      armed    <= armed_nx;
      if (s_done) s_ack <= ~s_ack;
      if (load)   act_q <= shadow;
    end
  end
endmodule

// File: rtl/dbr_bank.sv
module dbr_bank #(
  parameter int unsigned AW   = 4,
  parameter int unsigned NCMP = 3,
  parameter int unsigned CW   = 16,
  parameter int unsigned DW   = 8
) (
  input  logic               bus_clk,
  input  logic               bus_rst_n,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic               core_clk,
  input  logic               core_rst_n,
  input  logic               core_eoc,
  output logic               core_run,
  output logic [6:0]         core_ctl,
  output logic [7:0]         core_cfg,
  output logic [NCMP*CW-1:0] act_cmp,
  output logic [DW-1:0]      act_dly
);
  localparam int unsigned CB      = CW / 8;
  localparam int unsigned DB      = DW / 8;
  localparam int unsigned NSB     = NCMP * CB + DB;
  localparam int unsigned LAST_HI = dbr_pkg::A_SHD0 + NCMP * CB - 1;

  logic             run_q, en_rdy, cmd_rdy, s_busy, s_now;
  logic             en_req, en_req_s, en_ack, en_ack_s;
  logic             s_req, s_req_s, s_ack, s_ack_s;
  logic [1:0]       cmd_pend;
  logic [7:0]       cfg_q;
  logic [6:0]       ctl_hi;
  logic [NSB*8-1:0] shadow, act_q;

  dbr_bus_side #(.AW(AW), .NSB(NSB), .LAST_HI(LAST_HI)) u_bus (
    .clk(bus_clk), .rst_n(bus_rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .en_ack_s(en_ack_s), .s_ack_s(s_ack_s),
    .run_q(run_q), .ctl_hi(ctl_hi), .cfg_q(cfg_q), .shadow(shadow),
    .en_req(en_req), .s_req(s_req), .s_now(s_now), .en_rdy(en_rdy),
    .cmd_rdy(cmd_rdy), .s_busy(s_busy), .cmd_pend(cmd_pend)
  );

  dbr_tgl_sync u_sync_en_req (.clk(core_clk), .rst_n(core_rst_n), .tgl_in(en_req), .tgl_out(en_req_s));
  dbr_tgl_sync u_sync_s_req  (.clk(core_clk), .rst_n(core_rst_n), .tgl_in(s_req),  .tgl_out(s_req_s));
  dbr_tgl_sync u_sync_en_ack (.clk(bus_clk),  .rst_n(bus_rst_n),  .tgl_in(en_ack), .tgl_out(en_ack_s));
  dbr_tgl_sync u_sync_s_ack  (.clk(bus_clk),  .rst_n(bus_rst_n),  .tgl_in(s_ack),  .tgl_out(s_ack_s));

  dbr_core_side #(.NSB(NSB)) u_core (
    .clk(core_clk), .rst_n(core_rst_n), .en_req_s(en_req_s), .s_req_s(s_req_s),
    .run_bus(run_q), .s_now_bus(s_now), .shadow(shadow), .eoc(core_eoc),
    .en_ack(en_ack), .s_ack(s_ack), .core_run(core_run), .act_q(act_q)
  );

  assign core_ctl = ctl_hi;
  assign core_cfg = cfg_q;
  assign act_cmp  = act_q[NCMP*CW-1:0];
  assign act_dly  = act_q[NSB*8-1 -: DW];
endmodule

// File: rtl/dbr_bank_chk.sv
module dbr_bank_chk #(
  parameter int unsigned NCMP = 3,
  parameter int unsigned CW   = 16,
  parameter int unsigned DW   = 8,
  parameter int unsigned NSB  = 7
) (
  input logic               bus_clk,
  input logic               bus_rst_n,
  input logic               core_clk,
  input logic               core_rst_n,
  input logic               run_q,
  input logic               en_rdy,
  input logic               cmd_rdy,
  input logic               s_busy,
  input logic [1:0]         cmd_pend,
  input logic [7:0]         cfg_q,
  input logic [NSB*8-1:0]   shadow,
  input logic               core_run,
  input logic [NCMP*CW-1:0] act_cmp,
  input logic [DW-1:0]      act_dly
);
  AST_RUN_GATED: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !$stable(run_q) |-> $past(en_rdy)); // R2
  AST_CFG_STATIC: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !$stable(cfg_q) |-> !$past(run_q)); // R4
  AST_SHADOW_GATED: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (!$stable(shadow) && $past(run_q)) |-> $past(cmd_rdy)); // R5
  AST_CMD_IN_FLIGHT: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(|cmd_pend) |-> (s_busy && !cmd_rdy)); // R6
  AST_PEND_HELD: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    ($past(s_busy) && s_busy) |-> $stable(cmd_pend)); // R10
  AST_IDLE_HOLD: assert property (@(posedge core_clk) disable iff (!core_rst_n)
    (!$past(core_run) && !core_run) |-> $stable({act_dly, act_cmp})); // R11
endmodule

bind dbr_bank dbr_bank_chk #(.NCMP(NCMP), .CW(CW), .DW(DW), .NSB(NSB)) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .core_clk(core_clk), .core_rst_n(core_rst_n),
  .run_q(run_q), .en_rdy(en_rdy), .cmd_rdy(cmd_rdy), .s_busy(s_busy),
  .cmd_pend(cmd_pend), .cfg_q(cfg_q), .shadow(shadow), .core_run(core_run),
  .act_cmp(act_cmp), .act_dly(act_dly)
);

// File: tb/sim_dbr_bank.sv
module sim_dbr_bank;
  localparam int NB = 7;

  logic        bus_clk = 1'b0, core_clk = 1'b0;
  logic        bus_rst_n = 1'b0, core_rst_n = 1'b0;
  logic        bus_wr = 1'b0, core_eoc = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        core_run;
  logic [6:0]  core_ctl;
  logic [7:0]  core_cfg;
  logic [47:0] act_cmp;
  logic [7:0]  act_dly;

  int vectors = 0, miscompares = 0, mon_err = 0;
  bit done = 0;
  logic [7:0]  model [NB];
  logic [55:0] mon_a = '0, mon_b = '0;

  always #10 bus_clk  = ~bus_clk;
  always #6  core_clk = ~core_clk;

  dbr_bank u0 (.*);

  always @(negedge core_clk)
    if (core_rst_n && {act_dly, act_cmp} !== mon_a && {act_dly, act_cmp} !== mon_b)
      mon_err++;

  function automatic logic [55:0] packed_model();
    logic [55:0] v;
    for (int j = 0; j < NB; j++) v[8*j +: 8] = model[j];
    return v;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int j);
    return 8'((seed * 37 + j * 11 + 5) & 8'hFF);
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge bus_clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge bus_clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] s;
    bit ok = 0;
    for (int i = 0; i < 300 && !ok; i++) begin
      rd(4'd3, s);
      if (s[1:0] == 2'b11) ok = 1;
    end
    check(tag, 64'(ok), 64'd1);
  endtask

  task automatic fill(input int seed);
    for (int j = 0; j < NB; j++) begin
      model[j] = pat(seed, j);
      wr(4'(4 + j), model[j]);
    end
  endtask

  task automatic act_is(input string tag, input logic [55:0] exp);
    @(negedge core_clk);
    check(tag, 64'({act_dly, act_cmp}), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge bus_clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [55:0] cur;
    for (int j = 0; j < NB; j++) model[j] = '0;
    repeat (4) @(negedge bus_clk);
    bus_rst_n = 1'b1; core_rst_n = 1'b1;
    repeat (2) @(negedge bus_clk);

    // R1 reset state
    rd(4'd3, d); check("R1 status", 64'(d), 64'h03);
    for (int a = 0; a < 11; a++) begin
      if (a == 3) continue;
      rd(4'(a), d); check("R1 reg zero", 64'(d), 64'h00);
    end
    check("R1 core_run", 64'(core_run), 64'd0);
    act_is("R1 active zero", 56'd0);

    // R5 sweep while stopped, R11 no copy while stopped
    fill(1);
    for (int j = 0; j < NB; j++) begin
      rd(4'(4 + j), d); check("R5 shadow readback", 64'(d), 64'(model[j]));
    end
    repeat (10) @(negedge bus_clk);
    act_is("R11 hold while stopped", 56'd0);

    // R6 command while stopped is dropped
    wr(4'd2, 8'h01);
    rd(4'd2, d); check("R6 cmd stopped", 64'(d), 64'h00);
    rd(4'd3, d); check("R6 status stopped", 64'(d), 64'h03);

    // R4 config writable while stopped
    wr(4'd1, 8'h3C);
    rd(4'd1, d); check("R4 cfg stopped", 64'(d), 64'h3C);

    // R2 R3 R11 enable with protected bits
    mon_b = packed_model();
    wr(4'd0, 8'hA5);
    rd(4'd3, d); check("R2 en_rdy low", 64'(d[0]), 64'd0);
    rd(4'd0, d); check("R3 ctl written", 64'(d), 64'hA5);
    wait_ready("R2 ready return");
    check("R2 core_run", 64'(core_run), 64'd1);
    check("R3 core_ctl", 64'(core_ctl), 64'h52);
    act_is("R11 copy on enable", mon_b);
    mon_a = mon_b;

    // R4 R3 protection while running
    wr(4'd1, 8'hFF);
    rd(4'd1, d); check("R4 cfg held", 64'(d), 64'h3C);
    wr(4'd0, 8'h0B);
    rd(4'd0, d); check("R3 ctl held", 64'(d), 64'hA5);

    // R5 running writes accepted, no copy without command
    cur = packed_model();
    fill(2);
    rd(4'd6, d); check("R5 running write", 64'(d), 64'(model[2]));
    repeat (10) @(negedge bus_clk);
    act_is("R7 no copy before command", cur);

    // R7 immediate
    mon_b = packed_model();
    wr(4'd2, 8'h01);
    rd(4'd2, d); check("R6 pending now", 64'(d), 64'h01);
    rd(4'd3, d); check("R6 cmd_rdy low", 64'(d[1]), 64'd0);
    wait_ready("R7 complete");
    act_is("R7 immediate copy", mon_b);
    rd(4'd2, d); check("R6 self clear", 64'(d), 64'h00);
    mon_a = mon_b;

    // R8 R10 R5 end-of-cycle with blocked traffic
    cur = packed_model();
    fill(3);
    mon_b = packed_model();
    wr(4'd2, 8'h02);
    wr(4'd4, 8'h99);
    rd(4'd4, d); check("R5 busy write dropped", 64'(d), 64'(model[0]));
    wr(4'd2, 8'h01);
    rd(4'd2, d); check("R10 pending kept", 64'(d), 64'h02);
    repeat (40) @(negedge bus_clk);
    act_is("R8 wait for eoc", cur);
    rd(4'd3, d); check("R8 still busy", 64'(d[1]), 64'd0);
    @(negedge core_clk); core_eoc = 1'b1; @(negedge core_clk); core_eoc = 1'b0;
    wait_ready("R8 complete");
    act_is("R8 eoc copy", mon_b);
    mon_a = mon_b;

    // R13 stop while eoc pending
    cur = packed_model();
    fill(4);
    wr(4'd2, 8'h02);
    repeat (20) @(negedge bus_clk);
    wr(4'd0, 8'hA4);
    wait_ready("R13 ready after stop");
    check("R13 core stopped", 64'(core_run), 64'd0);
    act_is("R13 abandoned", cur);
    rd(4'd2, d); check("R13 cmd cleared", 64'(d), 64'h00);

    // R11 stopped writes do not reach active
    fill(5);
    repeat (20) @(negedge bus_clk);
    act_is("R11 stopped hold", cur);

    // R2 second change while not ready is dropped
    mon_b = packed_model();
    wr(4'd0, 8'hA5);
    wr(4'd0, 8'hA4);
    rd(4'd0, d); check("R2 change dropped", 64'(d[0]), 64'd1);
    wait_ready("R2 settle");
    check("R2 core_run kept", 64'(core_run), 64'd1);
    act_is("R11 second enable copy", mon_b);
    mon_a = mon_b;

    // configure automatic update
    wr(4'd0, 8'hA4);
    wait_ready("R4 stop for cfg");
    wr(4'd1, 8'h01);
    rd(4'd1, d); check("R4 auto set", 64'(d), 64'h01);
    wr(4'd0, 8'hA5);
    wait_ready("R4 restart");
    act_is("R11 restart copy", mon_a);

    // R9 automatic update, same-cycle write and start
    cur = packed_model();
    model[4] = 8'h5A;
    wr(4'd8, 8'h5A);
    rd(4'd3, d); check("R9 low byte no trigger", 64'(d), 64'h03);
    model[5] = 8'hC3;
    mon_b = packed_model();
    wr(4'd9, 8'hC3);
    rd(4'd3, d); check("R9 trigger busy", 64'(d[1]), 64'd0);
    rd(4'd2, d); check("R9 pending eoc", 64'(d), 64'h02);
    repeat (40) @(negedge bus_clk);
    act_is("R9 wait for eoc", cur);
    @(negedge core_clk); core_eoc = 1'b1; @(negedge core_clk); core_eoc = 1'b0;
    wait_ready("R9 complete");
    act_is("R9 copy with last byte", mon_b);
    mon_a = mon_b;

    check("R12 no mixed active value", 64'(mon_err), 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule